// File: doc/BRIEF.md
# Register Busy-Bit Scoreboard

This block tracks which architectural registers have a write outstanding in a pipeline. It holds one busy flag for each of the 32 registers. When an instruction is allowed to issue, the flag of its destination register is raised. When that instruction later commits, in program order, its destination flag drops again.

At issue, the block checks three register names: the two source operands and the destination. It returns one stall signal. The stall is high when a source is still awaiting a write (read-after-write) or when the destination already has a pending writer (write-after-write). One flag cannot count two writers, so the block refuses a second pending write to the same register rather than lose track of it. A flush input drops every flag when the pipeline is squashed.

Top module: `busy_scoreboard`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `busy_vec` is all zero.
- R2: An issue that is accepted sets bit `iss_rd` of `busy_vec` from the next cycle. Accepted means `iss_valid` is 1, `stall` is 0, `iss_rd_vld` is 1 and `iss_rd` is not 0. Bit i of `busy_vec` belongs to register i.
- R3: A commit (`cmt_valid` and `cmt_rd_vld` both 1) clears bit `cmt_rd` of `busy_vec` from the next cycle, unless R9 applies.
- R4: With `iss_valid` high, `stall` is 1 in the same cycle whenever a valid, nonzero source (`iss_rs1` or `iss_rs2`) names a register whose bit is set.
- R5: With `iss_valid` high, `stall` is 1 whenever the valid, nonzero `iss_rd` names a register whose bit is set, so no register ever has two pending writers.
- R6: Register 0 is never marked busy, and naming it in any field never raises `stall`.
- R7: A field whose valid flag is 0 never raises `stall` and changes no bit.
- R8: The lookups see a commit of the same cycle. A source or destination waiting only on the register being committed does not stall.
- R9: When an accepted issue and a commit name the same register in one cycle, the bit is set on the next cycle.
- R10: `flush` high clears every bit on the next cycle and overrides any set or clear in that cycle.
- R11: `stall` is 0 whenever `iss_valid` is 0, and an issue that is stalled or not valid changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all busy bits (pipeline squash) |
| iss_valid | input | 1 | An instruction is offered for issue this cycle |
| iss_rs1_vld | input | 1 | First source operand is used |
| iss_rs1 | input | 5 | First source register index |
| iss_rs2_vld | input | 1 | Second source operand is used |
| iss_rs2 | input | 5 | Second source register index |
| iss_rd_vld | input | 1 | Instruction writes a destination |
| iss_rd | input | 5 | Destination register index |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_rd_vld | input | 1 | Committing instruction has a destination |
| cmt_rd | input | 5 | Destination of the committing instruction |
| stall | output | 1 | Hold the offered instruction (RAW or WAW hazard) |
| busy_vec | output | 32 | Current busy flag of every register |

## Verification
The bench sweeps every register index through each of the three lookup fields. It covers the cycle in which a commit and a lookup or issue name the same register. A design that applied the commit after the lookup would stall one extra cycle. A design that let the clear win would lose the new writer's flag, and a later reader would then issue too early. Register 0 and fields with the valid flag low are driven against busy registers. A slip there would show as a false stall or a flag that never clears. Flush is driven together with an issue that would be accepted, to catch a bit that survives a squash. Last, a long pseudo-random run compares `stall` and `busy_vec` with a bench model every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Positions of the lookup ports in the probe array
  localparam int unsigned LK_RS1   = 0;
  localparam int unsigned LK_RS2   = 1;
  localparam int unsigned LK_RD    = 2;
  localparam int unsigned LK_COUNT = 3;
endpackage

// File: rtl/sb_decode.sv
// Turns a (valid, index) pair into a one-hot register mask; register 0 maps to nothing.
module sb_decode #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                vld,
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] mask
);
  assign mask[0] = 1'b0;
  for (genvar g = 1; g < NUM_REGS; g++) begin : g_bit
    assign mask[g] = vld && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/sb_probe.sv
// One lookup port: is the named register pending a write?
module sb_probe #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] view,
  input  logic                vld,
  input  logic [IDX_W-1:0]    idx,
  output logic                hit
);
  function automatic logic probe_hit(logic [NUM_REGS-1:0] v, logic en,
                                     logic [IDX_W-1:0] i);
    logic r;
    r = 1'b0;
    for (int k = 1; k < NUM_REGS; k++) begin
      if (en && i == IDX_W'(k) && v[k]) r = 1'b1;
    end
    return r;
  endfunction

  assign hit = probe_hit(view, vld, idx);
endmodule

// File: rtl/sb_bits.sv
// Busy flag storage: clear first, then set, flush over all.
module sb_bits #(
  parameter int NUM_REGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [NUM_REGS-1:0] set_mask,
  input  logic [NUM_REGS-1:0] clr_mask,
  output logic [NUM_REGS-1:0] busy_q,
  output logic [NUM_REGS-1:0] view
);
  // Flags as lookups see them: this cycle's commit already applied
  assign view = busy_q & ~clr_mask;

  always_ff @(posedge clk) begin
    if (!rst_n)     busy_q <= '0;
    else if (flush) busy_q <= '0;
    else            busy_q <= view | set_mask;
  end

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_q == '0));

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (set_mask & clr_mask) != '0)
      |=> ((busy_q & $past(set_mask & clr_mask)) == $past(set_mask & clr_mask)));

  assert_clear_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> ((busy_q & $past(clr_mask & ~set_mask)) == '0));
endmodule

// File: rtl/busy_scoreboard.sv
module busy_scoreboard #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                iss_valid,
  input  logic                iss_rs1_vld,
  input  logic [IDX_W-1:0]    iss_rs1,
  input  logic                iss_rs2_vld,
  input  logic [IDX_W-1:0]    iss_rs2,
  input  logic                iss_rd_vld,
  input  logic [IDX_W-1:0]    iss_rd,
  input  logic                cmt_valid,
  input  logic                cmt_rd_vld,
  input  logic [IDX_W-1:0]    cmt_rd,
  output logic                stall,
  output logic [NUM_REGS-1:0] busy_vec
);
  import sb_pkg::*;

  logic [NUM_REGS-1:0] set_mask, clr_mask, view;
  logic [LK_COUNT-1:0] lk_vld, lk_hit;
  logic [IDX_W-1:0]    lk_idx [LK_COUNT];
  logic                issue_fire;   // instruction accepted with a destination
  logic                commit_fire;  // committing instruction frees a destination

  assign lk_vld[LK_RS1] = iss_rs1_vld;
  assign lk_idx[LK_RS1] = iss_rs1;
  assign lk_vld[LK_RS2] = iss_rs2_vld;
  assign lk_idx[LK_RS2] = iss_rs2;
  assign lk_vld[LK_RD]  = iss_rd_vld;
  assign lk_idx[LK_RD]  = iss_rd;

  for (genvar p = 0; p < LK_COUNT; p++) begin : g_probe
    sb_probe #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_probe (
      .view (view),
      .vld  (lk_vld[p]),
      .idx  (lk_idx[p]),
      .hit  (lk_hit[p])
    );
  end

  assign stall       = iss_valid && (|lk_hit);
  assign issue_fire  = iss_valid && !stall && iss_rd_vld;
  assign commit_fire = cmt_valid && cmt_rd_vld;

  sb_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_set_dec (
    .vld (issue_fire), .idx (iss_rd), .mask (set_mask)
  );

  sb_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_clr_dec (
    .vld (commit_fire), .idx (cmt_rd), .mask (clr_mask)
  );

  sb_bits #(.NUM_REGS(NUM_REGS)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .busy_q   (busy_vec),
    .view     (view)
  );

  assert_reg0_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_vec[0]);

  assert_no_second_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask & view) == '0);

  assert_raw_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_rs1_vld && iss_rs1 != '0 && view[iss_rs1]) |-> stall);

  assert_issue_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && iss_rd != '0 && !flush) |=> busy_vec[$past(iss_rd)]);

  assert_idle_no_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !stall);

  assert_invalid_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_rs1_vld && !iss_rs2_vld && !iss_rd_vld) |-> !stall);
endmodule

// File: tb/busy_scoreboard_bench.sv
module busy_scoreboard_bench;
  localparam int N = 32;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         iss_valid = 1'b0, iss_rs1_vld = 1'b0, iss_rs2_vld = 1'b0, iss_rd_vld = 1'b0;
  logic [W-1:0] iss_rs1 = '0, iss_rs2 = '0, iss_rd = '0;
  logic         cmt_valid = 1'b0, cmt_rd_vld = 1'b0;
  logic [W-1:0] cmt_rd = '0;
  logic         stall;
  logic [N-1:0] busy_vec;

  int total = 0;
  int bad   = 0;
  logic [N-1:0] model = '0;

  always #4 clk = ~clk;  // 125 MHz

  busy_scoreboard u_busy_scoreboard (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .iss_valid(iss_valid), .iss_rs1_vld(iss_rs1_vld), .iss_rs1(iss_rs1),
    .iss_rs2_vld(iss_rs2_vld), .iss_rs2(iss_rs2),
    .iss_rd_vld(iss_rd_vld), .iss_rd(iss_rd),
    .cmt_valid(cmt_valid), .cmt_rd_vld(cmt_rd_vld), .cmt_rd(cmt_rd),
    .stall(stall), .busy_vec(busy_vec)
  );

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic pending(logic [N-1:0] v, logic en, logic [W-1:0] r);
    return en && (r != 0) && v[r];
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: stall actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: busy_vec actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check stall, clock, check flags at next negedge
  task automatic step(string req, logic fl, logic iv, logic v1, logic [W-1:0] s1,
                      logic v2, logic [W-1:0] s2, logic vd, logic [W-1:0] d,
                      logic cv, logic cd, logic [W-1:0] c);
    logic [N-1:0] freed;
    logic exp_stall;
    flush = fl; iss_valid = iv;
    iss_rs1_vld = v1; iss_rs1 = s1; iss_rs2_vld = v2; iss_rs2 = s2;
    iss_rd_vld = vd; iss_rd = d;
    cmt_valid = cv; cmt_rd_vld = cd; cmt_rd = c;
    freed = model;
    if (cv && cd && c != 0) freed[c] = 1'b0;
    exp_stall = iv && (pending(freed, v1, s1) || pending(freed, v2, s2) || pending(freed, vd, d));
    #1;
    check_bit(req, stall, exp_stall);
    if (fl) model = '0;
    else begin
      model = freed;
      if (iv && !exp_stall && vd && d != 0) model[d] = 1'b1;
    end
    @(negedge clk);
    check_vec(req, busy_vec, model);
    flush = 1'b0; iss_valid = 1'b0; cmt_valid = 1'b0;
  endtask

  task automatic issue(string req, logic [W-1:0] d);
    step(req, 0, 1, 0, 0, 0, 0, 1, d, 0, 0, 0);
  endtask

  task automatic commit(string req, logic [W-1:0] c);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, c);
  endtask

  initial begin
    @(negedge clk);
    check_vec("R1", busy_vec, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec("R1", busy_vec, '0);

    // R2, R4, R5 across every register; R3 at the end of each round
    for (int r = 1; r < N; r++) begin
      issue("R2", W'(r));
      step("R4", 0, 1, 1, W'(r), 0, 0, 0, 0, 0, 0, 0);
      step("R4", 0, 1, 0, 0, 1, W'(r), 1, W'((r % 31) + 1 == r ? 1 : (r % 31) + 1), 0, 0, 0);
      step("R5", 0, 1, 0, 0, 0, 0, 1, W'(r), 0, 0, 0);
      step("R11", 0, 0, 1, W'(r), 1, W'(r), 1, W'(r), 0, 0, 0);
      step("R7", 0, 1, 0, W'(r), 0, W'(r), 0, W'(r), 0, 0, 0);
      model = model;
      step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, W'(r));
      // drop any neighbour set by the R4 step above
      for (int q = 1; q < N; q++) if (model[q]) commit("R3", W'(q));
    end

    // R6: register 0 never busy, never stalls
    issue("R6", 0);
    step("R6", 0, 1, 1, 0, 1, 0, 1, 0, 0, 0, 0);
    check_vec("R6", busy_vec, '0);

    // R7: invalid commit changes nothing
    issue("R7", 9);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 9);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 9);

    // R8: commit of r9 releases a reader of r9 in the same cycle
    step("R8", 0, 1, 1, 9, 0, 0, 1, 10, 1, 1, 9);
    commit("R3", 10);

    // R9: writer of r12 commits while a new writer of r12 issues
    issue("R9", 12);
    step("R9", 0, 1, 0, 0, 0, 0, 1, 12, 1, 1, 12);
    check_vec("R9", busy_vec, 32'h1 << 12);

    // R10: flush clears all and overrides an accepted issue
    issue("R10", 3);
    issue("R10", 20);
    step("R10", 1, 1, 0, 0, 0, 0, 1, 7, 1, 1, 3);
    check_vec("R10", busy_vec, '0);

    // Pseudo-random run against the model (R2, R3, R4, R5, R8, R9)
    for (int k = 0; k < 4000; k++) begin
      logic [W-1:0] c;
      logic cv;
      cv = 1'b0; c = '0;
      for (int q = 1; q < N; q++) begin
        if (model[q] && ($urandom % 3 == 0)) begin cv = 1'b1; c = W'(q); end
      end
      step("R4", ($urandom % 200) == 0, $urandom % 4 != 0,
           $urandom % 4 != 0, W'($urandom), $urandom % 2 == 0, W'($urandom),
           $urandom % 5 != 0, W'($urandom), cv, 1'b1, c);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule